// File: doc/BRIEF.md
# Bimodal Speculative-Thread Fetch Selector

This block decides, once per cycle, which thread slot the instruction fetch unit serves next. It sits in a processor that runs compiler-partitioned speculative threads in program order. Slot 0 always holds the oldest thread, the non-speculative head. Higher slot numbers hold progressively younger speculative threads. For every slot the block receives a valid bit, a stall bit, the thread's start PC, its count of instructions in flight, and a resource-ok bit from an external demand predictor.

The selector works in one of two modes. When the start PCs of the two threads after the head both equal the head's start PC, the threads look like iterations of a loop. The block then treats them as independent and grants the eligible slot with the fewest instructions in flight. In all other cases the threads are treated as dependent, and fetch stays sequential: the head is served when it can fetch, and otherwise the oldest eligible speculative slot is served. A speculative slot is eligible only when its resource-ok bit is set. The head is not gated by that bit.

The mode is produced combinationally from the current inputs. The grant is registered, so it applies to the cycle after the inputs it was computed from.

Top module: `fetch_sel_top`

## Requirements
- R1: While reset (`rstN` low) is asserted, `grantValid` is 0, `grantIdx` is 0 and `grantOneHot` is all zeros.
- R2: `modeIndep` is 1 exactly when slots 0, 1 and 2 are valid and the start PCs of slots 1 and 2 both equal the start PC of slot 0. It follows the current inputs within the same cycle.
- R3: In dependent mode (`modeIndep` = 0), when slot 0 is valid and not stalled, the next-cycle grant is slot 0 (`grantIdx` = 0).
- R4: In dependent mode, when slot 0 cannot fetch, the next-cycle grant is the lowest-numbered eligible speculative slot.
- R5: A speculative slot (index 1 or above) is eligible only when it is valid, not stalled and has its resource-ok bit at 1. Slot 0 is eligible when it is valid and not stalled, whatever its resource-ok bit.
- R6: In independent mode, the next-cycle grant is the eligible slot with the smallest in-flight count. Slot 0 also competes under this rule.
- R7: In independent mode, equal in-flight counts resolve to the lowest slot index, which is the oldest thread.
- R8: When no slot is eligible, the next cycle shows `grantValid` = 0, `grantIdx` = 0 and `grantOneHot` = 0.
- R9: The grant outputs register the decision made from the inputs of the previous cycle. `grantOneHot` has bit `grantIdx` set and no other bit whenever `grantValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | NUM_SLOTS | Slot holds a live thread (slot 0 = head) |
| slotStall | input | NUM_SLOTS | Slot cannot fetch this cycle |
| slotResOk | input | NUM_SLOTS | Predictor says free resources exceed demand |
| slotStartPc | input | NUM_SLOTS x PC_W | Start PC of each slot's thread |
| slotInFlight | input | NUM_SLOTS x CNT_W | Instructions in flight per slot |
| grantValid | output | 1 | A slot is granted this cycle |
| grantIdx | output | $clog2(NUM_SLOTS) | Granted slot index |
| grantOneHot | output | NUM_SLOTS | Granted slot, one-hot |
| modeIndep | output | 1 | 1 = independent (loop) mode |

## Verification
A wrong mode decision shows up at the ports in two places. `modeIndep` is wrong in the same cycle, and one cycle later the grant points at a least-loaded slot where it should point at the oldest slot, or the other way round. A wrong eligibility term shows up one cycle later, as a grant to a slot that is stalled or gated, or as an idle grant while a slot could fetch. The bench drives biased random slot states in which start PCs repeat often and in-flight counts tie often. Every cycle it compares the grant against a behavioural model.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic modeIndep;   // loop heuristic fired
    logic anyElig;     // at least one slot may fetch
    logic headElig;    // head slot may fetch
  } selStrobe_t;

endpackage

// File: rtl/fetch_sel_ctrl.sv
module fetch_sel_ctrl #(
  parameter int NUM_SLOTS  = 8,
  parameter int PC_W       = 32,
  parameter int LOOK_AHEAD = 2
) (
  input  logic [NUM_SLOTS-1:0]           slotValid,
  input  logic [NUM_SLOTS-1:0]           slotStall,
  input  logic [NUM_SLOTS-1:0]           slotResOk,
  input  logic [NUM_SLOTS-1:0][PC_W-1:0] slotStartPc,
  output logic [NUM_SLOTS-1:0]           eligible,
  output fetch_sel_pkg::selStrobe_t      strobe
);
  localparam int WIN = LOOK_AHEAD + 1;

  // Eligibility: the head ignores resource gating, younger slots need it
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_elig
    if (g == 0) begin : g_head
      assign eligible[g] = slotValid[g] & ~slotStall[g];
    end else begin : g_spec
      assign eligible[g] = slotValid[g] & ~slotStall[g] & slotResOk[g];
    end
  end

  // Loop heuristic: the next LOOK_AHEAD threads restart at the head's PC
  logic loopHit;
  always_comb begin
    loopHit = &slotValid[WIN-1:0];
    for (int i = 1; i < WIN; i++) begin
      if (slotStartPc[i] != slotStartPc[0]) loopHit = 1'b0;
    end
  end

  assign strobe.modeIndep = loopHit;
  assign strobe.anyElig   = |eligible;
  assign strobe.headElig  = eligible[0];

endmodule

// File: rtl/fetch_sel_dp.sv
module fetch_sel_dp #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_SLOTS-1:0]            eligible,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] slotInFlight,
  input  fetch_sel_pkg::selStrobe_t       strobe,
  output logic                            grantValid,
  output logic [IDX_W-1:0]                grantIdx,
  output logic [NUM_SLOTS-1:0]            grantOneHot
);
  logic [IDX_W-1:0] oldestIdx;
  logic [IDX_W-1:0] leastIdx;
  logic [CNT_W-1:0] leastCnt;
  logic             leastFound;
  logic [IDX_W-1:0] nextIdx;

  // Oldest eligible slot: scan young to old so the oldest wins
  always_comb begin
    oldestIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (eligible[i]) oldestIdx = IDX_W'(i);
    end
  end

  // Least in-flight eligible slot; strict compare keeps the older on ties
  always_comb begin
    leastIdx   = '0;
    leastCnt   = '0;
    leastFound = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (eligible[i] && (!leastFound || slotInFlight[i] < leastCnt)) begin
        leastIdx   = IDX_W'(i);
        leastCnt   = slotInFlight[i];
        leastFound = 1'b1;
      end
    end
  end

  always_comb begin
    if (!strobe.anyElig)       nextIdx = '0;
    else if (strobe.modeIndep) nextIdx = leastIdx;
    else                       nextIdx = oldestIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid  <= 1'b0;
      grantIdx    <= '0;
      grantOneHot <= '0;
    end else begin
      grantValid  <= strobe.anyElig;
      grantIdx    <= nextIdx;
      grantOneHot <= strobe.anyElig ? (NUM_SLOTS'(1) << nextIdx) : '0;
    end
  end

  // R3: dependent mode keeps the head first
  a_r3_head_first: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.modeIndep && strobe.headElig) |=> (grantValid && grantIdx == '0));

  // R8: nothing eligible yields an idle grant
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.anyElig |=> (!grantValid && grantOneHot == '0));

  // R9: one-hot agrees with the index
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantOneHot == (NUM_SLOTS'(1) << grantIdx)));

  // R9: at most one slot granted
  a_r9_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot));

endmodule

// File: rtl/fetch_sel_top.sv
module fetch_sel_top #(
  parameter int NUM_SLOTS  = 8,
  parameter int PC_W       = 32,
  parameter int CNT_W      = 8,
  parameter int LOOK_AHEAD = 2,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_SLOTS-1:0]            slotValid,
  input  logic [NUM_SLOTS-1:0]            slotStall,
  input  logic [NUM_SLOTS-1:0]            slotResOk,
  input  logic [NUM_SLOTS-1:0][PC_W-1:0]  slotStartPc,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] slotInFlight,
  output logic                            grantValid,
  output logic [IDX_W-1:0]                grantIdx,
  output logic [NUM_SLOTS-1:0]            grantOneHot,
  output logic                            modeIndep
);
  fetch_sel_pkg::selStrobe_t strobe;
  logic [NUM_SLOTS-1:0]      eligible;

  fetch_sel_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .PC_W(PC_W), .LOOK_AHEAD(LOOK_AHEAD)
  ) i_ctrl (
    .slotValid(slotValid), .slotStall(slotStall), .slotResOk(slotResOk),
    .slotStartPc(slotStartPc), .eligible(eligible), .strobe(strobe)
  );

  fetch_sel_dp #(
    .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .eligible(eligible), .slotInFlight(slotInFlight),
    .strobe(strobe), .grantValid(grantValid), .grantIdx(grantIdx),
    .grantOneHot(grantOneHot)
  );

  assign modeIndep = strobe.modeIndep;

  // R5: a granted speculative slot had its resource bit set the cycle before
  a_r5_res_gate: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantIdx != '0) |-> (($past(slotResOk) & grantOneHot) != '0));

endmodule

// File: tb/test_fetch_sel_top.sv
module test_fetch_sel_top;
  localparam int N      = 8;
  localparam int PCW    = 32;
  localparam int CW     = 8;
  localparam int IW     = $clog2(N);
  localparam int PERIOD = 10;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic [N-1:0]           slotValid, slotStall, slotResOk;
  logic [N-1:0][PCW-1:0]  slotStartPc;
  logic [N-1:0][CW-1:0]   slotInFlight;
  logic                   grantValid;
  logic [IW-1:0]          grantIdx;
  logic [N-1:0]           grantOneHot;
  logic                   modeIndep;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  fetch_sel_top #(.NUM_SLOTS(N), .PC_W(PCW), .CNT_W(CW)) i_fetch_sel_top (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotStall(slotStall),
    .slotResOk(slotResOk), .slotStartPc(slotStartPc), .slotInFlight(slotInFlight),
    .grantValid(grantValid), .grantIdx(grantIdx), .grantOneHot(grantOneHot),
    .modeIndep(modeIndep)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, written from the requirements
  function automatic bit refIndep();
    return slotValid[0] && slotValid[1] && slotValid[2] &&
           slotStartPc[1] == slotStartPc[0] && slotStartPc[2] == slotStartPc[0];
  endfunction

  function automatic bit refElig(int s);
    if (s == 0) return slotValid[0] && !slotStall[0];
    return slotValid[s] && !slotStall[s] && slotResOk[s];
  endfunction

  function automatic int refGrant();
    int best = -1;
    for (int s = 0; s < N; s++) begin
      if (refElig(s)) begin
        if (best < 0) best = s;
        else if (refIndep() && slotInFlight[s] < slotInFlight[best]) best = s;
      end
    end
    return best;
  endfunction

  function automatic bit refTie(int g);
    for (int s = 0; s < N; s++)
      if (s != g && refElig(s) && slotInFlight[s] == slotInFlight[g]) return 1;
    return 0;
  endfunction

  // Inputs are already applied at a falling edge; check mode now, grant after next edge
  task automatic step();
    bit    ind;
    int    exp;
    string tag;
    #1;
    ind = refIndep();
    chk(modeIndep == ind, "R2 mode", int'(modeIndep), int'(ind));
    exp = refGrant();
    if (exp < 0)                       tag = "R8 idle";
    else if (ind && refTie(exp))       tag = "R7 tie";
    else if (ind)                      tag = "R6 least";
    else if (exp == 0)                 tag = "R3 head";
    else                               tag = "R4 oldest";
    @(negedge clk);
    if (exp < 0) begin
      chk(!grantValid && grantIdx == 0 && grantOneHot == 0, tag, int'(grantValid), 0);
    end else begin
      chk(grantValid && int'(grantIdx) == exp, tag, int'(grantIdx), exp);
      chk(grantOneHot == (N'(1) << exp), "R9 onehot", int'(grantOneHot), 1 << exp);
    end
  endtask

  task automatic setAll(input logic [N-1:0] v, input logic [N-1:0] st,
                        input logic [N-1:0] ok, input int pcMask);
    slotValid = v; slotStall = st; slotResOk = ok;
    for (int s = 0; s < N; s++) begin
      slotStartPc[s]  = ((pcMask >> s) & 1) != 0 ? 32'h200 : 32'h100;
      slotInFlight[s] = CW'(10);
    end
  endtask

  initial begin
    rstN = 1'b0;
    setAll('0, '0, '0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!grantValid && grantIdx == 0 && grantOneHot == 0, "R1 reset", int'(grantValid), 0);
    setAll('1, '0, '1, 0);
    @(negedge clk);
    chk(!grantValid && grantOneHot == 0, "R1 reset held", int'(grantOneHot), 0);
    rstN = 1'b1;
    setAll('0, '0, '0, 0);
    step();

    // R5: head granted with its resource bit low (dependent mode, PCs differ)
    setAll('1, '0, 8'h00, 32'h02);
    step();
    // R5: spec slot with lowest count but resource bit low is skipped (indep mode)
    setAll('1, 8'h01, 8'hFB, 0);
    slotInFlight[2] = CW'(1);
    slotInFlight[3] = CW'(3);
    step();
    chk(grantIdx != 2, "R5 gated slot", int'(grantIdx), 3);
    // R7: all counts equal in independent mode -> slot 0
    setAll('1, '0, '1, 0);
    step();
    // R4: head stalled, dependent mode
    setAll('1, 8'h07, '1, 32'h04);
    step();
    // R8: nothing valid
    setAll('0, '0, '1, 0);
    step();
    // R2: slot 2 invalid breaks the loop heuristic
    setAll(8'hFB, '0, '1, 0);
    slotInFlight[5] = CW'(0);
    step();
    // R6: saturated counts versus small count
    setAll('1, '0, '1, 0);
    for (int s = 0; s < N; s++) slotInFlight[s] = 8'hFF;
    slotInFlight[6] = CW'(254);
    step();

    // Biased random sweep
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < N; s++) begin
        slotValid[s]    = $urandom_range(0, 5) != 0;
        slotStall[s]    = $urandom_range(0, 3) == 0;
        slotResOk[s]    = $urandom_range(0, 3) != 0;
        slotStartPc[s]  = $urandom_range(0, 4) == 0 ? 32'h300 : 32'h100;
        slotInFlight[s] = $urandom_range(0, 9) == 0 ? 8'hFF : CW'($urandom_range(0, 5));
      end
      if ($urandom_range(0, 7) == 0) slotValid = '0;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule